// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a 10-bit successive-approximation analog-to-digital converter. Software writes a start request. The sequencer then waits for the next Q4 instruction phase and starts a conversion clock after a short launch delay. At the first conversion clock it opens the sample switch. It then tries each result bit from the most significant to the least significant against an external comparator. When the last bit is resolved, it loads the result register, drops its busy bit and sets a sticky interrupt flag, all in the same cycle.

The analog parts stay outside the block and appear only as ports: the comparator, the trial DAC, the sample-and-hold and the RC oscillator. The RC oscillator reaches the block as a tick input. `clk_i` runs at twice the oscillator rate, so one clock is half an oscillator period. An instruction cycle lasts `CYC_CLKS` clocks, and `q4_i` is high for one clock in each instruction cycle.

Top module: `sar_seq`

## Requirements
- R1: While reset is held, and after it is released, `busy_o`=0, `flag_o`=0, `result_o`=0, `dac_code_o`=0 and `sample_en_o`=1.
- R2: A start pulse captured at clock edge W sets `busy_o` after W. The conversion launches at the first edge L>W at which `q4_i` is high. A start written at a Q4 edge therefore waits for the next Q4.
- R3: Source code `clk_sel_i`=2'b11 selects the RC source. For it, `sample_en_o` falls after edge L+1+`CYC_CLKS`. For the other codes it falls after edge L+1, which is half an oscillator period.
- R4: When `sample_en_o` falls, `dac_code_o` is 10'b10_0000_0000. Each later conversion clock keeps the bit under trial if `comp_i`=1 (input at or above the DAC level), clears it otherwise, and sets the next lower bit to 1. The final result is the binary code of the input.
- R5: For codes 00, 01 and 10, one conversion clock (TAD) lasts 4·4^code clocks. `busy_o` falls exactly 10·TAD clocks after `sample_en_o` falls. For the RC code, each `rc_tick_i` pulse is one conversion clock.
- R6: `result_o` keeps its old value while `busy_o` is 1. It changes only on the edge where `busy_o` falls at completion, and `flag_o` is set on that same edge.
- R7: A start pulse while `busy_o`=1 is ignored: the completion time and the result are unchanged, and no new conversion follows.
- R8: A `start_clr_i` pulse while busy aborts the conversion. After the next edge `busy_o`=0 and `sample_en_o`=1, and `result_o` and `flag_o` are unchanged.
- R9: `sample_en_o` is 1 again from the completion edge onward.
- R10: `flag_o` stays set until `flag_clr_i` is pulsed; hardware never clears it. If completion and `flag_clr_i` fall in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, two per oscillator period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| q4_i | input | 1 | High for one clock in the Q4 phase of each instruction cycle |
| clk_sel_i | input | 2 | Conversion clock source; 2'b11 = RC tick |
| rc_tick_i | input | 1 | RC oscillator tick, one per conversion clock in RC mode |
| start_set_i | input | 1 | Software writes the start bit to 1 |
| start_clr_i | input | 1 | Software writes the start bit to 0 (abort) |
| flag_clr_i | input | 1 | Software clears the interrupt flag |
| comp_i | input | 1 | Comparator: 1 when input is at or above the DAC level |
| dac_code_o | output | 10 | Trial code for the DAC |
| sample_en_o | output | 1 | Sample switch closed when 1 |
| result_o | output | 10 | Result register |
| busy_o | output | 1 | Start/busy bit, 1 while a conversion is pending or running |
| flag_o | output | 1 | Sticky conversion-complete interrupt flag |

## Verification
Two things can meet on one clock edge: the completion edge, where hardware sets the flag, and a software flag clear. The bench computes the completion edge from the Q4 launch edge, the launch delay and 10·TAD. It raises `flag_clr_i` for exactly that cycle and expects the flag to remain set. A start write in mid-conversion tests a start request that arrives during a busy conversion; the completion time must still match the computed value. An abort followed by a fresh conversion shows that the stale state is dropped.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CONV} st_e;
  localparam logic [1:0] SEL_RC = 2'b11;
endpackage

// File: rtl/sar_seq_launch.sv
// Q4 alignment and launch delay; go_o marks the first conversion clock.
module sar_seq_launch #(
  parameter int CYC_CLKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_i,
  input  logic q4_i,
  input  logic rc_sel_i,
  output logic go_o
);
  localparam int DLY_W = $clog2(CYC_CLKS + 2);
  localparam logic [DLY_W-1:0] DLY_OSC = DLY_W'(1);
  localparam logic [DLY_W-1:0] DLY_RC  = DLY_W'(CYC_CLKS + 1);

  logic             counting_q;
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      counting_q <= 1'b0;
      cnt_q      <= '0;
    end else if (!wait_i) begin
      counting_q <= 1'b0;
      cnt_q      <= '0;
    end else if (!counting_q && q4_i) begin
      counting_q <= 1'b1;
      cnt_q      <= rc_sel_i ? DLY_RC : DLY_OSC;
    end else if (counting_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign go_o = wait_i && counting_q && (cnt_q == DLY_W'(1));
endmodule

// File: rtl/sar_seq_tick.sv
// Conversion clock enable: divided system clock or external RC tick.
module sar_seq_tick #(
  parameter int TAD_BASE = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  input  logic       rc_tick_i,
  output logic       tick_o
);
  localparam int TAD_MAX = TAD_BASE << 4;
  localparam int DIV_W   = $clog2(TAD_MAX);

  logic [DIV_W-1:0] div_q;
  logic             div_hit;

  function automatic int tad_of(logic [1:0] s);
    return TAD_BASE << (2 * int'(s));
  endfunction

  assign div_hit = (int'(div_q) == tad_of(sel_i) - 1);
  assign tick_o  = run_i && ((sel_i == sar_seq_pkg::SEL_RC) ? rc_tick_i : div_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= '0;
    else if (!run_i)  div_q <= '0;
    else if (tick_o)  div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/sar_seq_sar.sv
// Successive-approximation register, MSB first.
module sar_seq_sar #(
  parameter int N_BITS = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              tick_i,
  input  logic              comp_i,
  output logic [N_BITS-1:0] code_o,
  output logic              last_o
);
  localparam int STEP_W = $clog2(N_BITS + 1);

  logic [STEP_W-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     step_q <= '0;
    else if (load_i) step_q <= '0;
    else if (tick_i) step_q <= step_q + 1'b1;
  end

  assign last_o = (int'(step_q) == N_BITS - 1);

  for (genvar i = 0; i < N_BITS; i++) begin : g_bit
    localparam int RES_AT = N_BITS - 1 - i;
    localparam int SET_AT = N_BITS - 2 - i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        code_o[i] <= 1'b0;
      end else if (load_i) begin
        code_o[i] <= (i == N_BITS - 1);
      end else if (tick_i) begin
        if (int'(step_q) == RES_AT)      code_o[i] <= comp_i;
        else if (int'(step_q) == SET_AT) code_o[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int N_BITS   = 10,
  parameter int CYC_CLKS = 8,
  parameter int TAD_BASE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              q4_i,
  input  logic [1:0]        clk_sel_i,
  input  logic              rc_tick_i,
  input  logic              start_set_i,
  input  logic              start_clr_i,
  input  logic              flag_clr_i,
  input  logic              comp_i,
  output logic [N_BITS-1:0] dac_code_o,
  output logic              sample_en_o,
  output logic [N_BITS-1:0] result_o,
  output logic              busy_o,
  output logic              flag_o
);
  st_e               state_q;
  logic [1:0]        sel_q;
  logic              go, tick, last, done, load;
  logic [N_BITS-1:0] code;
  logic [N_BITS-1:0] result_q;
  logic              flag_q;

  sar_seq_launch #(.CYC_CLKS(CYC_CLKS)) i_launch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wait_i   (state_q == ST_WAIT),
    .q4_i     (q4_i),
    .rc_sel_i (sel_q == SEL_RC),
    .go_o     (go)
  );

  sar_seq_tick #(.TAD_BASE(TAD_BASE)) i_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (state_q == ST_CONV),
    .sel_i     (sel_q),
    .rc_tick_i (rc_tick_i),
    .tick_o    (tick)
  );

  assign load = (state_q == ST_WAIT) && go && !start_clr_i;
  assign done = (state_q == ST_CONV) && tick && last && !start_clr_i;

  sar_seq_sar #(.N_BITS(N_BITS)) i_sar (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .tick_i (tick && state_q == ST_CONV && !start_clr_i),
    .comp_i (comp_i),
    .code_o (code),
    .last_o (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_set_i) begin
          state_q <= ST_WAIT;
          sel_q   <= clk_sel_i;
        end
        ST_WAIT: begin
          if (start_clr_i) state_q <= ST_IDLE;
          else if (go)     state_q <= ST_CONV;
        end
        ST_CONV: if (start_clr_i || done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // last tick resolves bit 0 straight from the comparator
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   result_q <= '0;
    else if (done) result_q <= {code[N_BITS-1:1], comp_i};
  end

  // hardware set wins over software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (done)       flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign dac_code_o  = code;
  assign sample_en_o = (state_q != ST_CONV);
  assign result_o    = result_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign flag_o      = flag_q;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int N_BITS = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_clr_i,
  input logic              flag_clr_i,
  input logic [N_BITS-1:0] dac_code_o,
  input logic              sample_en_o,
  input logic [N_BITS-1:0] result_o,
  input logic              busy_o,
  input logic              flag_o
);
  p_flag_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !flag_clr_i |=> flag_o);

  p_flag_at_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $fell(busy_o));

  p_result_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $stable(result_o));

  p_result_at_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> $fell(busy_o));

  p_sample_off_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_en_o |-> busy_o);

  p_msb_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sample_en_o) |-> dac_code_o == {1'b1, {(N_BITS-1){1'b0}}});

  p_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_clr_i && !flag_clr_i |=>
      !busy_o && sample_en_o && $stable(result_o) && $stable(flag_o));
endmodule

bind sar_seq sar_seq_chk #(.N_BITS(N_BITS)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_clr_i (start_clr_i),
  .flag_clr_i  (flag_clr_i),
  .dac_code_o  (dac_code_o),
  .sample_en_o (sample_en_o),
  .result_o    (result_o),
  .busy_o      (busy_o),
  .flag_o      (flag_o)
);

// File: tb/test_sar_seq.sv
module test_sar_seq;
  localparam int CLK_NS = 10;
  localparam int CYC    = 8;
  localparam int RC_PER = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       q4 = 1'b0, rc_tick = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       st_set = 1'b0, st_clr = 1'b0, fl_clr = 1'b0;
  logic [9:0] vin = '0;
  logic       comp;
  logic [9:0] dac, result;
  logic       sample_en, busy, flag;
  int         cyc = 0;
  int         total = 0, bad = 0;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    q4      <= (cyc % CYC == CYC - 2);
    rc_tick <= (cyc % RC_PER == 0);
  end
  assign comp = (vin >= dac);

  sar_seq i_sar_seq (
    .clk_i(clk), .rst_ni(rst_n), .q4_i(q4), .clk_sel_i(sel), .rc_tick_i(rc_tick),
    .start_set_i(st_set), .start_clr_i(st_clr), .flag_clr_i(fl_clr), .comp_i(comp),
    .dac_code_o(dac), .sample_en_o(sample_en), .result_o(result), .busy_o(busy), .flag_o(flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic run_conv(input logic [1:0] s, input logic [9:0] v,
                          input bit restart, input bit collide);
    int ws, e0, dly, tad, t_samp, t_done, dac0, held;
    logic [9:0] old;
    @(negedge clk);
    sel = s; vin = v; st_set = 1'b1; old = result;
    @(negedge clk);
    st_set = 1'b0; ws = cyc;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    e0 = ws + 1;
    while (e0 % CYC != CYC - 1) e0++;
    dly = (s == 2'b11) ? 1 + CYC : 1;
    tad = 4 << (2 * int'(s));
    t_samp = -1; t_done = -1; dac0 = -1; held = 1;
    for (int k = 0; k < 20000 && t_done < 0; k++) begin
      @(negedge clk);
      st_set = 1'b0; fl_clr = 1'b0;
      if (t_samp < 0 && !sample_en) begin t_samp = cyc; dac0 = int'(dac); end
      if (busy && result != old) held = 0;
      if (!busy) t_done = cyc;
      else begin
        if (restart && cyc == e0 + dly + 3) st_set = 1'b1;
        if (collide && cyc == e0 + dly + 10 * tad - 1) fl_clr = 1'b1;
      end
    end
    chk(t_samp == e0 + dly, (s == 2'b11) ? "R3 rc launch delay" : "R2 R3 q4 launch",
        t_samp, e0 + dly);
    chk(dac0 == 512, "R4 first trial msb", dac0, 512);
    if (s != 2'b11)
      chk(t_done == e0 + dly + 10 * tad, restart ? "R7 timing kept" : "R5 conv time",
          t_done, e0 + dly + 10 * tad);
    chk(result == v, "R4 result code", int'(result), int'(v));
    chk(held == 1, "R6 old result held", held, 1);
    chk(flag == 1'b1, collide ? "R10 set wins over clear" : "R6 flag at done", int'(flag), 1);
    chk(sample_en == 1'b1, "R9 sampling resumes", int'(sample_en), 1);
    if (restart) begin
      @(negedge clk);
      chk(busy == 1'b0, "R7 no restart", int'(busy), 0);
    end
  endtask

  task automatic clear_flag();
    @(negedge clk); fl_clr = 1'b1;
    @(negedge clk); fl_clr = 1'b0;
    chk(flag == 1'b0, "R10 software clear", int'(flag), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 190000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [9:0] old_r;
    repeat (3) @(negedge clk);
    chk(busy == 0 && flag == 0 && result == 0 && dac == 0 && sample_en == 1,
        "R1 in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 0 && flag == 0 && result == 0 && dac == 0 && sample_en == 1,
        "R1 after reset", int'(flag), 0);

    // full code sweep on the fastest oscillator-based clock
    for (int v = 0; v < 1024; v++) run_conv(2'b00, 10'(v), 1'b0, 1'b0);

    // sticky flag: idles at 1 until cleared
    repeat (20) @(negedge clk);
    chk(flag == 1'b1, "R10 sticky flag", int'(flag), 1);
    clear_flag();
    repeat (10) @(negedge clk);
    chk(flag == 1'b0, "R10 stays clear", int'(flag), 0);

    run_conv(2'b01, 10'd0, 1'b0, 1'b0);
    run_conv(2'b01, 10'd1023, 1'b0, 1'b0);
    run_conv(2'b01, 10'd341, 1'b0, 1'b0);
    run_conv(2'b10, 10'h2AA, 1'b0, 1'b0);
    run_conv(2'b10, 10'h155, 1'b0, 1'b0);
    run_conv(2'b11, 10'd0, 1'b0, 1'b0);
    run_conv(2'b11, 10'd1023, 1'b0, 1'b0);
    run_conv(2'b11, 10'd600, 1'b0, 1'b0);

    // start written during a conversion
    run_conv(2'b01, 10'd682, 1'b1, 1'b0);

    // completion and software flag clear on the same edge
    run_conv(2'b00, 10'd77, 1'b0, 1'b1);
    clear_flag();
    run_conv(2'b00, 10'd900, 1'b0, 1'b1);

    // abort in mid-conversion
    clear_flag();
    old_r = result;
    @(negedge clk); sel = 2'b01; vin = 10'd5; st_set = 1'b1;
    @(negedge clk); st_set = 1'b0;
    while (sample_en) @(negedge clk);
    repeat (30) @(negedge clk);
    st_clr = 1'b1;
    @(negedge clk); st_clr = 1'b0;
    chk(busy == 1'b0 && sample_en == 1'b1, "R8 abort idles", int'(busy), 0);
    chk(result == old_r, "R8 abort keeps result", int'(result), int'(old_r));
    chk(flag == 1'b0, "R8 abort keeps flag", int'(flag), 0);
    repeat (200) @(negedge clk);
    chk(flag == 1'b0 && result == old_r, "R8 no late completion", int'(flag), 0);

    // abort before launch, then a clean conversion
    @(negedge clk); sel = 2'b00; st_set = 1'b1;
    @(negedge clk); st_set = 1'b0; st_clr = 1'b1;
    @(negedge clk); st_clr = 1'b0;
    chk(busy == 1'b0, "R8 abort while waiting", int'(busy), 0);
    repeat (20) @(negedge clk);
    chk(sample_en == 1'b1 && busy == 1'b0, "R8 no launch after abort", int'(sample_en), 1);
    run_conv(2'b00, 10'd513, 1'b0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule